// File: doc/BRIEF.md
# Constant-Time Verify and Conditional Move

This unit compares two byte strings of equal length that sit in a word-addressed data memory, and then copies one of two candidate strings to a destination area. The candidate is picked by the comparison outcome. If the two compared strings are identical, the primary candidate (a recovered session key) is copied. If they differ, the fallback candidate (a pseudorandom string) is copied instead.

The unit drives one memory read port and one memory write port. Both ports use 64-bit words. The read port returns data one cycle after the request. The unit's timing depends on the length alone. The compare stage reads every word pair, even after a difference has been found. The copy stage reads both candidates for every word and merges them with an all-ones or all-zeros mask that is built from the mismatch bit. The comparison result therefore never changes the cycle count, the addresses issued or which words are written.

A start pulse captures five base addresses and a word count N, with N at least 1. A start with a length of zero is not accepted. After exactly 4·N busy cycles, a one-cycle done pulse is raised together with the mismatch flag.

Top module: `ct_verify_move`

## Requirements
- R1: When `done_o` is high, `mismatch_o` is 1 if any of the N word pairs A[i], B[i] differ in any bit, and 0 if all N pairs are equal.
- R2: Mismatch accumulates over the scan and never clears before `done_o`. A difference in the first word pair only, or in one bit of the last pair only, still gives `mismatch_o`=1.
- R3: When the strings match, destination words D[0..N-1] receive the primary words K[0..N-1].
- R4: When the strings differ, destination words D[0..N-1] receive the fallback words F[0..N-1].
- R5: Starting in the cycle after the accepted start, the unit issues one read per cycle for 4·N cycles, in this order:
  - A[i], B[i] for i = 0..N-1;
  - then K[i], F[i] for i = 0..N-1.
- R6: `done_o` rises in exactly the (4·N+1)-th cycle after the cycle in which start was sampled. It stays high for one cycle. The timing is the same whether or not the strings match.
- R7: The unit writes exactly N words, at D[0..N-1] only, with no write during the compare stage.
- R8: A start pulse that arrives while the unit is busy is ignored. The running operation keeps its addresses and its length, and the area named by the ignored request is not written.
- R9: After reset, `mem_re_o`, `mem_we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle and `len_i` is not zero |
| len_i | input | LEN_W | Length N in 64-bit words |
| a_base_i | input | ADDR_W | Base address of the first compared string |
| b_base_i | input | ADDR_W | Base address of the second compared string |
| key_base_i | input | ADDR_W | Base address of the primary candidate |
| fb_base_i | input | ADDR_W | Base address of the fallback candidate |
| dst_base_i | input | ADDR_W | Base address of the destination |
| mem_re_o | output | 1 | Read request |
| mem_raddr_o | output | ADDR_W | Read word address |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the request |
| mem_we_o | output | 1 | Write enable |
| mem_waddr_o | output | ADDR_W | Write word address |
| mem_wdata_o | output | DATA_W | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Compare outcome, valid with `done_o` |

## Verification
A corrupted step counter or stage flag shows up at the read port in the very next cycle, as an address out of the expected A/B/K/F order. It also shows up at the end of the run as a done pulse that arrives on the wrong cycle. A mismatch accumulator that clears or fails to set shows up only at the copy stage. There the destination receives the wrong candidate, starting with the first write two cycles after the compare stage ends. A merge mask of the wrong polarity corrupts every destination word. A busy flag that can be restarted is caught when a mid-run start redirects the addresses or writes the sentinel area.

// File: rtl/ct_vm_pkg.sv
package ct_vm_pkg;
  localparam int unsigned WORD_W = 64;

  // tag travelling with a read request to the cycle its data returns
  typedef struct packed {
    logic vld;
    logic op;    // 0: A or primary word, 1: B or fallback word
    logic cpy;   // 0: compare stage, 1: copy stage
    logic last;  // final read of the operation
  } rd_tag_t;
endpackage

// File: rtl/ct_vm_seq.sv
module ct_vm_seq
  import ct_vm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] a_base_i,
  input  logic [ADDR_W-1:0] b_base_i,
  input  logic [ADDR_W-1:0] key_base_i,
  input  logic [ADDR_W-1:0] fb_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output rd_tag_t           tag_o,
  output logic              busy_o,
  output logic              accept_o
);
  logic              busy_q, op_q, cpy_q;
  logic [LEN_W-1:0]  idx_q, len_q, widx_q;
  logic [ADDR_W-1:0] a_q, b_q, k_q, f_q, d_q;
  rd_tag_t           tag_q;
  logic              pair_end, last_c;
  logic [ADDR_W-1:0] base_c;

  assign accept_o = start_i & ~busy_q & (len_i != '0);
  assign pair_end = (idx_q == len_q - LEN_W'(1));
  assign last_c   = busy_q & op_q & cpy_q & pair_end;

  always_comb begin
    unique case ({cpy_q, op_q})
      2'b00:   base_c = a_q;
      2'b01:   base_c = b_q;
      2'b10:   base_c = k_q;
      default: base_c = f_q;
    endcase
  end

  assign re_o    = busy_q;
  assign raddr_o = base_c + ADDR_W'(idx_q);
  assign waddr_o = d_q + ADDR_W'(widx_q);
  assign tag_o   = tag_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      cpy_q  <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      widx_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      k_q    <= '0;
      f_q    <= '0;
      d_q    <= '0;
      tag_q  <= '0;
    end else begin
      tag_q  <= '{vld: busy_q, op: op_q, cpy: cpy_q, last: last_c};
      widx_q <= idx_q;
      if (accept_o) begin
        busy_q <= 1'b1;
        op_q   <= 1'b0;
        cpy_q  <= 1'b0;
        idx_q  <= '0;
        len_q  <= len_i;
        a_q    <= a_base_i;
        b_q    <= b_base_i;
        k_q    <= key_base_i;
        f_q    <= fb_base_i;
        d_q    <= dst_base_i;
      end else if (busy_q) begin
        op_q <= ~op_q;
        if (op_q) begin
          if (pair_end) begin
            idx_q <= '0;
            if (cpy_q) busy_q <= 1'b0;
            else       cpy_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + LEN_W'(1);
          end
        end
      end
    end
  end

  // R8: a start while busy leaves the captured operands untouched
  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(len_q) && $stable(d_q) && $stable(a_q));
  // R5: reads alternate between the two operands of a pair
  a_r5_op_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && !$past(accept_o) |-> op_q != $past(op_q));
endmodule

// File: rtl/ct_vm_cmp.sv
module ct_vm_cmp
  import ct_vm_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  rd_tag_t           tag_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              diff_o
);
  logic [DATA_W-1:0] hold_q;
  logic              diff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      diff_q <= 1'b0;
    end else begin
      if (tag_i.vld && !tag_i.op) hold_q <= rdata_i;
      if (clr_i) diff_q <= 1'b0;
      else if (tag_i.vld && tag_i.op && !tag_i.cpy)
        diff_q <= diff_q | (|(hold_q ^ rdata_i));  // no early exit
    end
  end

  assign hold_o = hold_q;
  assign diff_o = diff_q;

  // R2: once set, the mismatch bit stays until the next accepted start
  a_r2_mismatch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_q && !clr_i |=> diff_q);
endmodule

// File: rtl/ct_vm_sel.sv
module ct_vm_sel
  import ct_vm_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_tag_t           tag_i,
  input  logic              diff_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [DATA_W-1:0] fb_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [DATA_W-1:0] mask;

  // branch-free pick: all ones selects the fallback word
  assign mask    = {DATA_W{diff_i}};
  assign wdata_o = (key_i & ~mask) | (fb_i & mask);
  assign we_o    = tag_i.vld & tag_i.op & tag_i.cpy;

  // R7: at most one write per two cycles
  a_r7_write_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
endmodule

// File: rtl/ct_verify_move.sv
module ct_verify_move
  import ct_vm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] a_base_i,
  input  logic [ADDR_W-1:0] b_base_i,
  input  logic [ADDR_W-1:0] key_base_i,
  input  logic [ADDR_W-1:0] fb_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic              mismatch_o
);
  rd_tag_t           tag;
  logic              busy, accept, diff;
  logic [DATA_W-1:0] hold;

  ct_vm_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .len_i,
    .a_base_i, .b_base_i, .key_base_i, .fb_base_i, .dst_base_i,
    .re_o(mem_re_o), .raddr_o(mem_raddr_o), .waddr_o(mem_waddr_o),
    .tag_o(tag), .busy_o(busy), .accept_o(accept)
  );

  ct_vm_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni, .clr_i(accept), .tag_i(tag),
    .rdata_i(mem_rdata_i), .hold_o(hold), .diff_o(diff)
  );

  ct_vm_sel #(.DATA_W(DATA_W)) u_sel (
    .clk_i, .rst_ni, .tag_i(tag), .diff_i(diff),
    .key_i(hold), .fb_i(mem_rdata_i),
    .we_o(mem_we_o), .wdata_o(mem_wdata_o)
  );

  assign done_o     = tag.vld & tag.last;
  assign mismatch_o = diff;

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: done never overlaps an issuing cycle
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_re_o);
  // R7: no write without a read one cycle earlier
  a_r7_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
endmodule

// File: tb/ct_verify_move_tb.sv
`timescale 1ns/1ps
module ct_verify_move_tb;
  localparam int AW = 10, LW = 8, DW = 64;
  localparam int A0 = 0, B0 = 32, K0 = 64, F0 = 96, D0 = 128, S0 = 160;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] a_b = '0, b_b = '0, k_b = '0, f_b = '0, d_b = '0;
  logic          re, we, done, mism;
  logic [AW-1:0] raddr, waddr;
  logic [DW-1:0] rdata, wdata;
  logic [DW-1:0] mem [0:255];
  int checks = 0, errors = 0, writes = 0, bad_writes = 0;
  logic in_cmp = 1'b0;

  always #2 clk = ~clk;

  ct_verify_move #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .a_base_i(a_b), .b_base_i(b_b), .key_base_i(k_b), .fb_base_i(f_b),
    .dst_base_i(d_b), .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .done_o(done), .mismatch_o(mism));

  always @(posedge clk) begin
    if (re) rdata <= mem[raddr[7:0]];
    if (we) begin
      mem[waddr[7:0]] <= wdata;
      writes <= writes + 1;
      if (in_cmp) bad_writes <= bad_writes + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int n, input int diff_word, input logic [63:0] flip);
    for (int i = 0; i < 256; i++) mem[i] = 64'hdead_0000_0000_0000 | 64'(i);
    for (int i = 0; i < n; i++) begin
      mem[A0+i] = {32'h0a0a_0000 + 32'(i), 32'h1357_9bdf};
      mem[B0+i] = mem[A0+i] ^ ((i == diff_word) ? flip : 64'h0);
      mem[K0+i] = {32'h4b45_5900, 32'(i * 7 + 1)};
      mem[F0+i] = {32'hfb00_0000, 32'(~i)};
    end
  endtask

  // run one operation, optionally with a spurious start at cycle spur_at
  task automatic run(input int n, input bit exp_mis, input string tag, input int spur_at);
    int cyc = 0, reads = 0, order_bad = 0, done_at = -1;
    logic [AW-1:0] exp_a;
    writes = 0; bad_writes = 0;
    @(negedge clk);
    len = LW'(n); a_b = AW'(A0); b_b = AW'(B0); k_b = AW'(K0); f_b = AW'(F0); d_b = AW'(D0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_cmp = 1'b1;
    while (done_at < 0 && cyc < 2000) begin
      cyc++;
      if (cyc == 2 * n + 1) in_cmp = 1'b0;
      if (re) begin
        int s = cyc - 1;
        int i = (s % (2 * n)) / 2;
        if (s < 2 * n) exp_a = AW'((s % 2 == 0) ? A0 + i : B0 + i);
        else           exp_a = AW'((s % 2 == 0) ? K0 + i : F0 + i);
        if (raddr != exp_a) order_bad++;
        reads++;
      end
      if (done) begin
        done_at = cyc;
        chk(mism == exp_mis, {"R1 R2 mismatch ", tag}, 64'(mism), 64'(exp_mis));
      end
      if (cyc == spur_at) begin
        start = 1'b1; len = 8'd2; a_b = AW'(S0); d_b = AW'(S0);
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    in_cmp = 1'b0;
    if (done_at < 0) begin
      errors++;
      $display("FAIL watchdog %s actual=hang expected=done", tag);
    end
    chk(done_at == 4 * n + 1, {"R6 done cycle ", tag}, 64'(done_at), 64'(4 * n + 1));
    chk(!done, {"R6 single pulse ", tag}, 64'(done), 64'h0);
    chk(reads == 4 * n && order_bad == 0, {"R5 read order ", tag}, 64'(order_bad), 64'h0);
    chk(writes == n && bad_writes == 0, {"R7 write count ", tag}, 64'(writes), 64'(n));
    for (int i = 0; i < n; i++) begin
      logic [63:0] e = exp_mis ? mem[F0+i] : mem[K0+i];
      chk(mem[D0+i] == e, exp_mis ? "R4 fallback copy" : "R3 key copy", mem[D0+i], e);
    end
    chk(mem[D0+n] == (64'hdead_0000_0000_0000 | 64'(D0 + n)), {"R7 past end ", tag},
        mem[D0+n], 64'hdead_0000_0000_0000 | 64'(D0 + n));
    chk(mem[S0] == (64'hdead_0000_0000_0000 | 64'(S0)), {"R8 sentinel ", tag},
        mem[S0], 64'hdead_0000_0000_0000 | 64'(S0));
  endtask

  task automatic t_reset();
    #1;
    chk(!re && !we && !done, "R9 reset outputs", {61'h0, re, we, done}, 64'h0);
  endtask

  task automatic t_match(input int n);
    fill(n, -1, 64'h0);
    run(n, 1'b0, "match", -1);
  endtask

  task automatic t_first_diff();
    fill(5, 0, 64'hffff_0000_0000_0000);
    run(5, 1'b1, "first word differs", -1);
  endtask

  task automatic t_last_bit();
    fill(6, 5, 64'h1);
    run(6, 1'b1, "last word one bit", -1);
  endtask

  task automatic t_single_word();
    fill(1, 0, 64'h8000_0000_0000_0000);
    run(1, 1'b1, "single word mismatch", -1);
    fill(1, -1, 64'h0);
    run(1, 1'b0, "single word match", -1);
  endtask

  task automatic t_busy_start();
    fill(4, 2, 64'h10);
    run(4, 1'b1, "start while busy", 5);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_match(4);
    t_first_diff();
    t_last_bit();
    t_single_word();
    t_busy_start();
    t_match(16);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule